// File: doc/BRIEF.md
# Sub-Vector Swizzle Remapper

This block turns one sub-vector group access into register addresses, one for each sub-element. Each request carries five things: a swizzle descriptor (an enable flag and one 2-bit lane index for each sub-element), the group size, a base register number, an element index, and a flag that says whether the register is a source or a destination. The block finds the register that each sub-element of the group maps to. It also flags swizzles that cannot be legal. Source swizzles may read the same lane more than once. A destination swizzle must be a true permutation of the lanes in use.

Requests enter through a valid/ready stream, and results leave through a second valid/ready stream one cycle later. The block holds one result in an output register. It accepts a new request when that register is empty or when the current result is being taken in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the result stays unchanged and no input is accepted. The swizzle table that supplies the descriptor, the register file and the arithmetic are handled elsewhere.

Top module: `swz_remap`

## Requirements
- R1: During and after reset, `out_valid` is 0 until a request is accepted.
- R2: A request accepted at a clock edge (`in_valid` and `in_ready` both high) appears at the output with `out_valid` high right after that edge.
- R3: A result that is stalled (`out_valid` high, `out_ready` low) keeps its address, lane-enable and illegal outputs stable, and `in_ready` is low. When `out_ready` is high, `in_ready` is high.
- R4: `in_subvl` gives the group size minus one: codes 0, 1, 2 and 3 mean 1, 2, 3 and 4 sub-elements. `out_lane_en` has exactly its low group-size bits set.
- R5: Sub-element k takes its lane index from bits [2k+1:2k] of `in_swz`.
- R6: When `in_active` is 0, or the group size is 1, sub-element k uses lane k and `out_illegal` is 0.
- R7: Each enabled sub-element k gives `out_addr[7k+6:7k] = (base + elem*size + lane[k]) mod 128`. The slice for a disabled sub-element is 0.
- R8: In source mode (`in_dst`=0), several sub-elements may name the same lane, and this is not flagged.
- R9: In destination mode (`in_dst`=1), any two enabled sub-elements that name the same lane set `out_illegal`.
- R10: When a swizzle is applied, an enabled sub-element whose lane index is greater than or equal to the group size sets `out_illegal`. This holds in both modes.
- R11: The index fields of disabled sub-elements have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when valid |
| in_active | input | 1 | Swizzle descriptor enabled |
| in_swz | input | 8 | Packed lane indices, 2 bits per sub-element |
| in_subvl | input | 2 | Group size minus one |
| in_dst | input | 1 | 1 = destination register, 0 = source |
| in_base | input | 7 | Base register number |
| in_elem | input | 6 | Element index within the vector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 28 | Remapped register per sub-element, 7 bits each |
| out_lane_en | output | 4 | Enabled sub-elements |
| out_illegal | output | 1 | Swizzle is not allowed for this access |

## Verification
The bench uses the default parameters: four lanes, 7-bit register numbers and 6-bit element indices. With these values every group size from 1 to 4 can be reached, every index can point outside a short group, and the address sum can wrap past register 127. Random stall lengths on `out_ready` exercise the hold rules of the output stream. Directed vectors cover repeated lanes in both modes, garbage in unused fields, and the largest base and element index.

// File: rtl/swz_pkg.sv
package swz_pkg;
  typedef enum logic {
    SWZ_SRC = 1'b0,
    SWZ_DST = 1'b1
  } swz_mode_e;
endpackage

// File: rtl/swz_lane_decode.sv
module swz_lane_decode #(
  parameter int LANES = 4,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic                   active_i,
  input  logic [LANES*IDX_W-1:0] swz_i,
  input  logic [IDX_W-1:0]       svl_code_i,
  output logic [LANES*IDX_W-1:0] idx_o,
  output logic [LANES-1:0]       en_o,
  output logic                   range_err_o
);
  logic             use_swz;
  logic [LANES-1:0] lane_bad;

  assign use_swz = active_i && (svl_code_i != '0);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IDX_W-1:0] field;
    assign field = swz_i[k*IDX_W +: IDX_W];
    assign en_o[k] = (IDX_W'(k) <= svl_code_i);
    assign idx_o[k*IDX_W +: IDX_W] = use_swz ? field : IDX_W'(k);
    assign lane_bad[k] = use_swz && en_o[k] && (field > svl_code_i);
  end

  assign range_err_o = |lane_bad;
endmodule

// File: rtl/swz_perm_check.sv
module swz_perm_check #(
  parameter int LANES = 4,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES*IDX_W-1:0] idx_i,
  input  logic [LANES-1:0]       en_i,
  output logic                   dup_o
);
  logic [LANES*LANES-1:0] clash;

  for (genvar j = 0; j < LANES; j++) begin : g_row
    for (genvar k = 0; k < LANES; k++) begin : g_col
      if (k > j) begin : g_pair
        assign clash[j*LANES+k] = en_i[j] && en_i[k] &&
          (idx_i[j*IDX_W +: IDX_W] == idx_i[k*IDX_W +: IDX_W]);
      end else begin : g_none
        assign clash[j*LANES+k] = 1'b0;
      end
    end
  end

  assign dup_o = |clash;
endmodule

// File: rtl/swz_addr_gen.sv
module swz_addr_gen #(
  parameter int LANES  = 4,
  parameter int REG_W  = 7,
  parameter int ELEM_W = 6,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [REG_W-1:0]       base_i,
  input  logic [ELEM_W-1:0]      elem_i,
  input  logic [IDX_W-1:0]       svl_code_i,
  input  logic [LANES*IDX_W-1:0] idx_i,
  input  logic [LANES-1:0]       en_i,
  output logic [LANES*REG_W-1:0] addr_o
);
  logic [REG_W-1:0] stride;
  logic [REG_W-1:0] group_base;

  assign stride     = REG_W'(svl_code_i) + REG_W'(1);
  assign group_base = base_i + REG_W'(elem_i) * stride;

  for (genvar k = 0; k < LANES; k++) begin : g_addr
    assign addr_o[k*REG_W +: REG_W] = en_i[k]
      ? group_base + REG_W'(idx_i[k*IDX_W +: IDX_W])
      : '0;
  end
endmodule

// File: rtl/swz_remap.sv
module swz_remap
  import swz_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int REG_W  = 7,
  parameter int ELEM_W = 6,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_active,
  input  logic [LANES*IDX_W-1:0] in_swz,
  input  logic [IDX_W-1:0]       in_subvl,
  input  logic                   in_dst,
  input  logic [REG_W-1:0]       in_base,
  input  logic [ELEM_W-1:0]      in_elem,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*REG_W-1:0] out_addr,
  output logic [LANES-1:0]       out_lane_en,
  output logic                   out_illegal
);
  logic [LANES*IDX_W-1:0] lane_idx;
  logic [LANES-1:0]       lane_en;
  logic                   range_err;
  logic                   dup_lane;
  logic [LANES*REG_W-1:0] addr_nxt;
  logic                   illegal_nxt;
  logic                   take;
  swz_mode_e              mode;

  assign mode = swz_mode_e'(in_dst);

  swz_lane_decode #(.LANES(LANES)) u_decode (
    .active_i    (in_active),
    .swz_i       (in_swz),
    .svl_code_i  (in_subvl),
    .idx_o       (lane_idx),
    .en_o        (lane_en),
    .range_err_o (range_err)
  );

  swz_perm_check #(.LANES(LANES)) u_perm (
    .idx_i (lane_idx),
    .en_i  (lane_en),
    .dup_o (dup_lane)
  );

  swz_addr_gen #(.LANES(LANES), .REG_W(REG_W), .ELEM_W(ELEM_W)) u_addr (
    .base_i     (in_base),
    .elem_i     (in_elem),
    .svl_code_i (in_subvl),
    .idx_i      (lane_idx),
    .en_i       (lane_en),
    .addr_o     (addr_nxt)
  );

  assign illegal_nxt = range_err || ((mode == SWZ_DST) && dup_lane);
  assign in_ready    = !out_valid || out_ready;
  assign take        = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_lane_en <= '0;
      out_illegal <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_addr    <= addr_nxt;
      out_lane_en <= lane_en;
      out_illegal <= illegal_nxt;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/swz_remap_chk.sv
module swz_remap_chk #(
  parameter int LANES = 4,
  parameter int REG_W = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [LANES*REG_W-1:0] out_addr,
  input logic [LANES-1:0]       out_lane_en,
  input logic                   out_illegal
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) &&
      $stable(out_lane_en) && $stable(out_illegal));

  assert_stall_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_lane_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_lane_en[0] &&
      ((out_lane_en & (out_lane_en + LANES'(1))) == '0));

  assert_single_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ($countones(out_lane_en) == 1) |-> !out_illegal);

  for (genvar k = 0; k < LANES; k++) begin : g_off
    assert_off_lane_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_lane_en[k] |-> out_addr[k*REG_W +: REG_W] == '0);
  end
endmodule

bind swz_remap swz_remap_chk #(.LANES(LANES), .REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_addr    (out_addr),
  .out_lane_en (out_lane_en),
  .out_illegal (out_illegal)
);

// File: tb/sim_swz_remap.sv
module sim_swz_remap;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_active = 1'b0;
  logic [7:0]  in_swz = '0;
  logic [1:0]  in_subvl = '0;
  logic        in_dst = 1'b0;
  logic [6:0]  in_base = '0;
  logic [5:0]  in_elem = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [27:0] out_addr;
  logic [3:0]  out_lane_en;
  logic        out_illegal;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swz_remap u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_active(in_active), .in_swz(in_swz), .in_subvl(in_subvl),
    .in_dst(in_dst), .in_base(in_base), .in_elem(in_elem),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_lane_en(out_lane_en), .out_illegal(out_illegal)
  );

  function automatic void ref_model(input logic act, input logic [7:0] swz,
      input logic [1:0] svl, input logic dst, input logic [6:0] base,
      input logic [5:0] elem, output logic [27:0] addr,
      output logic [3:0] en, output logic ill);
    int n;
    int idx[4];
    logic use_swz;
    n = int'(svl) + 1;
    use_swz = act && (n > 1);
    addr = '0;
    en = '0;
    ill = 1'b0;
    for (int k = 0; k < 4; k++) begin
      idx[k] = use_swz ? int'(swz[2*k +: 2]) : k;
      if (k < n) begin
        en[k] = 1'b1;
        addr[7*k +: 7] = 7'((int'(base) + int'(elem) * n + idx[k]) % 128);
        if (use_swz && idx[k] >= n) ill = 1'b1;
      end
    end
    if (dst)
      for (int j = 0; j < n; j++)
        for (int k = j + 1; k < n; k++)
          if (idx[j] == idx[k]) ill = 1'b1;
  endfunction

  task automatic check_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_out(input logic [27:0] ea, input logic [3:0] ee,
      input logic ei, input string tag);
    checks++;
    if (out_addr !== ea || out_lane_en !== ee || out_illegal !== ei) begin
      fails++;
      $display("FAIL %s: addr=%h en=%b ill=%b expected addr=%h en=%b ill=%b",
               tag, out_addr, out_lane_en, out_illegal, ea, ee, ei);
    end
  endtask

  // Called at a negedge; returns at a negedge.
  task automatic apply(input logic act, input logic [7:0] swz, input logic [1:0] svl,
      input logic dst, input logic [6:0] base, input logic [5:0] elem,
      input int stall, input string tag);
    logic [27:0] ea;
    logic [3:0]  ee;
    logic        ei;
    in_active = act; in_swz = swz; in_subvl = svl; in_dst = dst;
    in_base = base; in_elem = elem;
    in_valid = 1'b1;
    out_ready = 1'b1;
    #1;
    check_bit(in_ready, 1'b1, "R3 ready while consumer ready");
    ref_model(act, swz, svl, dst, base, elem, ea, ee, ei);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = (stall == 0);
    check_bit(out_valid, 1'b1, "R2 valid one cycle after accept");
    check_out(ea, ee, ei, tag);
    for (int s = 0; s < stall; s++) begin
      @(posedge clk);
      @(negedge clk);
      check_bit(out_valid, 1'b1, "R3 valid held under stall");
      check_bit(in_ready, 1'b0, "R3 input blocked under stall");
      check_out(ea, ee, ei, "R3 result held under stall");
    end
    out_ready = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R1 out_valid low in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R1 out_valid low after reset");

    apply(1'b0, 8'hE4, 2'd3, 1'b1, 7'd10, 6'd2, 0, "R6 inactive identity");
    apply(1'b0, 8'h00, 2'd3, 1'b1, 7'd10, 6'd2, 1, "R6 inactive ignores dup field");
    apply(1'b1, 8'hFF, 2'd0, 1'b1, 7'd5,  6'd9, 0, "R6 single lane identity");
    apply(1'b1, 8'h1E, 2'd3, 1'b1, 7'd0,  6'd1, 2, "R5 field layout permutation");
    apply(1'b1, 8'h00, 2'd3, 1'b0, 7'd20, 6'd3, 0, "R8 source repeated lane");
    apply(1'b1, 8'h00, 2'd3, 1'b1, 7'd20, 6'd3, 0, "R9 destination repeated lane");
    apply(1'b1, 8'h42, 2'd3, 1'b1, 7'd20, 6'd3, 0, "R9 destination pair clash");
    apply(1'b1, 8'h02, 2'd1, 1'b0, 7'd8,  6'd4, 0, "R10 index past group size");
    apply(1'b1, 8'hF1, 2'd1, 1'b1, 7'd8,  6'd4, 0, "R11 unused fields ignored");
    apply(1'b1, 8'h06, 2'd2, 1'b1, 7'd30, 6'd5, 1, "R4 three lane group");
    apply(1'b1, 8'h1B, 2'd3, 1'b1, 7'd127, 6'd63, 0, "R7 address wrap");

    for (int v = 0; v < 400; v++) begin
      logic [7:0] rs;
      rs = 8'($urandom);
      if (v % 4 == 0) rs = 8'hE4 ^ ({6'd0, 2'($urandom)} << (2 * ($urandom % 4)));
      apply(1'($urandom), rs, 2'($urandom), 1'($urandom), 7'($urandom),
            6'($urandom), int'($urandom % 3), "R7 random address and flag");
    end

    @(posedge clk);
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R3 result drained when taken");

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule